// File: doc/BRIEF.md
# Matrix Remap Element Index Generator

This block sits beside the element loop of a vector unit. Each cycle the loop sequencer advances through elements 0, 1, 2 and so on. The block turns that linear position into a reshaped element offset for one operand. It treats the operand as a 1D, 2D or 3D array whose axes need not be powers of two. A permutation code picks which axis counts fastest, so the same data can be walked in row order, column order (transposed) or any other axis nesting. When the array holds fewer elements than the loop is long, the counters wrap back to zero, and elements are presented again on purpose. This lets one register area accumulate over several passes.

A configuration load captures the three axis sizes, the permutation code and a base offset. A start pulse begins a run at element 0, and each step pulse moves to the next element. After an interruption, a restart pulse with a saved element index rebuilds the counters by stepping silently from element 0. It then raises valid on exactly the offset an uninterrupted run would have produced. An error flag marks any offset that lands beyond the register file. Several instances, each with its own configuration, can serve the different operands of one instruction.

Top module: `remap_index_gen`

## Requirements
- R1: While reset is asserted and directly after it, valid and rangeErr are low.
- R2: Each size field holds the axis size minus one: a field value of v (0 to 31) means v+1 positions. With permutation code 0, element n maps to offset base + (n mod total), where total is the product of the three sizes.
- R3: The offset is base + x + X*y + X*Y*z, where X and Y are the x and y sizes. The permutation code gives the axes from fastest to slowest: 0 x,y,z; 1 x,z,y; 2 y,x,z; 3 y,z,x; 4 z,x,y; 5 z,y,x; codes 6 and 7 act as code 0.
- R4: After the last combination of the three counters, all of them return to zero and the sequence repeats for as long as stepping continues.
- R5: When at least two axes have size 1, the offset is base + (n mod size of the remaining axis) for every permutation code.
- R6: The cycle after a start pulse, valid is high and the offset equals the configured base (element 0).
- R7: While valid, a step pulse advances exactly one element, and the new offset appears the cycle after the step. Without a step (and without start, restart or load), valid and offset hold. A step while valid is low has no effect.
- R8: A restart with saved index k keeps valid low for k cycles. Valid then rises, k cycles after the restart edge (at once when k is 0), with the offset of element k of an uninterrupted run.
- R9: rangeErr is high exactly when valid is high and the offset is at least REG_COUNT (default 128).
- R10: A configuration load drops valid the following cycle. The new sizes, permutation and base apply from the next start or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Capture the shape configuration |
| cfgXdim | input | DIM_W | x axis size minus one |
| cfgYdim | input | DIM_W | y axis size minus one |
| cfgZdim | input | DIM_W | z axis size minus one |
| cfgPerm | input | 3 | Axis nesting order code |
| cfgBase | input | ELEM_W | Base offset added to the index |
| start | input | 1 | Begin a run at element 0 |
| step | input | 1 | Advance one element |
| restart | input | 1 | Resume at a saved element index |
| restartIdx | input | ELEM_W | Saved element index for restart |
| offset | output | 3*DIM_W+1 | Remapped element offset |
| valid | output | 1 | Offset is meaningful |
| rangeErr | output | 1 | Offset lies beyond the register file |

## Verification
The assertions check on every cycle that the error flag never rises without valid. They also check that offset and valid hold while no control pulse arrives, that a start yields the base offset, and that load and restart set valid as stated. Whether the offset is right across a sequence can only be shown by the bench's scenarios. That covers the axis nesting of each permutation code, the wrap at the product of the sizes, the collapse to linear order when two axes have size 1, and agreement between a resumed run and an uninterrupted one. The bench compares these against its own model over table and random shapes.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_RUN
  } remapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // counters back to element 0
    logic advance;  // move one element along
  } remapStrobe_t;

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int ELEM_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              start,
  input  logic              step,
  input  logic              restart,
  input  logic [ELEM_W-1:0] restartIdx,
  output remapStrobe_t      strobe,
  output logic              valid
);

  remapState_t       state;
  logic [ELEM_W-1:0] seekLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      seekLeft <= '0;
    end else if (cfgLoad) begin
      state <= ST_IDLE;
    end else if (restart) begin
      seekLeft <= restartIdx;
      state    <= (restartIdx == '0) ? ST_RUN : ST_SEEK;
    end else if (start) begin
      state <= ST_RUN;
    end else if (state == ST_SEEK) begin
      seekLeft <= seekLeft - 1'b1;
      if (seekLeft == ELEM_W'(1)) state <= ST_RUN;
    end
  end

  always_comb begin
    strobe.clear   = cfgLoad | restart | start;
    strobe.advance = !strobe.clear &&
                     ((state == ST_SEEK) || (state == ST_RUN && step));
  end

  assign valid = (state == ST_RUN);

endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int DIM_W     = 5,
  parameter int ELEM_W    = 7,
  parameter int REG_COUNT = 128,
  localparam int OFF_W    = 3 * DIM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [DIM_W-1:0]  cfgXdim,
  input  logic [DIM_W-1:0]  cfgYdim,
  input  logic [DIM_W-1:0]  cfgZdim,
  input  logic [2:0]        cfgPerm,
  input  logic [ELEM_W-1:0] cfgBase,
  input  remapStrobe_t      strobe,
  output logic [OFF_W-1:0]  offset,
  output logic              overRange
);

  localparam int AXES = 3;

  logic [DIM_W-1:0]  dimM1   [AXES];
  logic [DIM_W-1:0]  cnt     [AXES];
  logic [DIM_W-1:0]  nextCnt [AXES];
  logic [1:0]        order   [AXES];
  logic [2:0]        perm;
  logic [ELEM_W-1:0] base;
  logic [OFF_W-1:0]  size    [AXES];
  logic [OFF_W-1:0]  weight  [AXES];
  logic [OFF_W-1:0]  term    [AXES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < AXES; a++) dimM1[a] <= '0;
      perm <= '0;
      base <= '0;
    end else if (cfgLoad) begin
      dimM1[0] <= cfgXdim;
      dimM1[1] <= cfgYdim;
      dimM1[2] <= cfgZdim;
      perm     <= cfgPerm;
      base     <= cfgBase;
    end
  end

  // axis order, fastest first
  always_comb begin
    case (perm)
      3'd1:    order = '{2'd0, 2'd2, 2'd1};
      3'd2:    order = '{2'd1, 2'd0, 2'd2};
      3'd3:    order = '{2'd1, 2'd2, 2'd0};
      3'd4:    order = '{2'd2, 2'd0, 2'd1};
      3'd5:    order = '{2'd2, 2'd1, 2'd0};
      default: order = '{2'd0, 2'd1, 2'd2};
    endcase
  end

  // ripple carry through the nested counters
  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int a = 0; a < AXES; a++) nextCnt[a] = cnt[a];
    for (int lvl = 0; lvl < AXES; lvl++) begin
      if (carry) begin
        if (cnt[order[lvl]] == dimM1[order[lvl]]) begin
          nextCnt[order[lvl]] = '0;
        end else begin
          nextCnt[order[lvl]] = cnt[order[lvl]] + 1'b1;
          carry = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < AXES; a++) cnt[a] <= '0;
    end else if (strobe.clear) begin
      for (int a = 0; a < AXES; a++) cnt[a] <= '0;
    end else if (strobe.advance) begin
      for (int a = 0; a < AXES; a++) cnt[a] <= nextCnt[a];
    end
  end

  // per-axis stride and weighted term
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    assign size[a] = OFF_W'(dimM1[a]) + OFF_W'(1);
    if (a == 0) begin : g_unit
      assign weight[a] = OFF_W'(1);
    end else if (a == 1) begin : g_row
      assign weight[a] = size[0];
    end else begin : g_plane
      assign weight[a] = size[0] * size[1];
    end
    assign term[a] = OFF_W'(cnt[a]) * weight[a];
  end

  assign offset    = OFF_W'(base) + term[0] + term[1] + term[2];
  assign overRange = (offset >= OFF_W'(REG_COUNT));

endmodule

// File: rtl/remap_index_gen.sv
module remap_index_gen
  import remap_pkg::*;
#(
  parameter int DIM_W     = 5,
  parameter int ELEM_W    = 7,
  parameter int REG_COUNT = 128,
  localparam int OFF_W    = 3 * DIM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [DIM_W-1:0]  cfgXdim,
  input  logic [DIM_W-1:0]  cfgYdim,
  input  logic [DIM_W-1:0]  cfgZdim,
  input  logic [2:0]        cfgPerm,
  input  logic [ELEM_W-1:0] cfgBase,
  input  logic              start,
  input  logic              step,
  input  logic              restart,
  input  logic [ELEM_W-1:0] restartIdx,
  output logic [OFF_W-1:0]  offset,
  output logic              valid,
  output logic              rangeErr
);

  remapStrobe_t strobe;
  logic         overRange;

  remap_ctrl #(.ELEM_W(ELEM_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .start(start), .step(step),
    .restart(restart), .restartIdx(restartIdx), .strobe(strobe), .valid(valid)
  );

  remap_datapath #(.DIM_W(DIM_W), .ELEM_W(ELEM_W), .REG_COUNT(REG_COUNT)) i_dp (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgXdim(cfgXdim),
    .cfgYdim(cfgYdim), .cfgZdim(cfgZdim), .cfgPerm(cfgPerm), .cfgBase(cfgBase),
    .strobe(strobe), .offset(offset), .overRange(overRange)
  );

  assign rangeErr = valid & overRange;

endmodule

// File: rtl/remap_index_gen_chk.sv
module remap_index_gen_chk #(
  parameter int DIM_W  = 5,
  parameter int ELEM_W = 7,
  localparam int OFF_W = 3 * DIM_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic [ELEM_W-1:0] cfgBase,
  input logic              start,
  input logic              step,
  input logic              restart,
  input logic [ELEM_W-1:0] restartIdx,
  input logic [OFF_W-1:0]  offset,
  input logic              valid,
  input logic              rangeErr
);

  logic [ELEM_W-1:0] baseCopy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        baseCopy <= '0;
    else if (cfgLoad) baseCopy <= cfgBase;
  end

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> valid); // R9

  AST_START_AT_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !restart && !cfgLoad) |=> (valid && offset == OFF_W'(baseCopy))); // R6

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !step && !start && !restart && !cfgLoad) |=> (valid && $stable(offset))); // R7

  AST_LOAD_DROPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !valid); // R10

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !cfgLoad && restartIdx == '0) |=> valid); // R8

  AST_RESTART_SEEK: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !cfgLoad && restartIdx != '0) |=> !valid); // R8

endmodule

bind remap_index_gen remap_index_gen_chk #(.DIM_W(DIM_W), .ELEM_W(ELEM_W)) i_chk (.*);

// File: tb/test_remap_index_gen.sv
module test_remap_index_gen;

  localparam int DIM_W  = 5;
  localparam int ELEM_W = 7;
  localparam int OFF_W  = 3 * DIM_W + 1;
  localparam int REGS   = 128;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgLoad = 1'b0;
  logic [DIM_W-1:0]  cfgXdim = '0, cfgYdim = '0, cfgZdim = '0;
  logic [2:0]        cfgPerm = '0;
  logic [ELEM_W-1:0] cfgBase = '0;
  logic              start = 1'b0, step = 1'b0, restart = 1'b0;
  logic [ELEM_W-1:0] restartIdx = '0;
  logic [OFF_W-1:0]  offset;
  logic              valid, rangeErr;

  int nChecks = 0;
  int nErrs   = 0;

  always #10 clk = ~clk;  // 50 MHz

  remap_index_gen i_remap_index_gen (.*);

  // xd, yd, zd, perm, base, length
  localparam int VEC [9][6] = '{
    '{3, 0, 0, 0,   0, 16},  // R2 4x1 cycles 0..3
    '{1, 2, 0, 0,   5, 13},  // R4 2x3 wraps
    '{2, 1, 1, 2,   0, 14},  // R3 y fastest
    '{2, 1, 1, 3,  10, 14},  // R3
    '{1, 2, 3, 4,   0, 30},  // R3
    '{3, 2, 1, 5,   3, 30},  // R3
    '{2, 2, 2, 7,   0, 30},  // R3 code 7 acts as 0
    '{0, 6, 0, 5,   0, 20},  // R5
    '{3, 3, 0, 0, 120, 16}   // R9 crosses the limit
  };

  function automatic int modelIdx(int xd, int yd, int zd, int perm, int n);
    int sz[3];
    int c[3];
    int ord[3];
    sz[0] = xd + 1; sz[1] = yd + 1; sz[2] = zd + 1;
    c = '{0, 0, 0};
    case (perm)
      1: ord = '{0, 2, 1};
      2: ord = '{1, 0, 2};
      3: ord = '{1, 2, 0};
      4: ord = '{2, 0, 1};
      5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    for (int s = 0; s < n; s++) begin
      for (int l = 0; l < 3; l++) begin
        if (c[ord[l]] == sz[ord[l]] - 1) c[ord[l]] = 0;
        else begin c[ord[l]]++; break; end
      end
    end
    return c[0] + sz[0] * c[1] + sz[0] * sz[1] * c[2];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
  endtask

  task automatic loadCfg(int xd, int yd, int zd, int perm, int base);
    cfgXdim = DIM_W'(xd); cfgYdim = DIM_W'(yd); cfgZdim = DIM_W'(zd);
    cfgPerm = 3'(perm); cfgBase = ELEM_W'(base); cfgLoad = 1'b1;
    @(negedge clk); cfgLoad = 1'b0;
  endtask

  task automatic pulseStart;
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulseStep;
    step = 1'b1; @(negedge clk); step = 1'b0;
  endtask

  task automatic pulseRestart(int k);
    restartIdx = ELEM_W'(k); restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  task automatic checkOff(string req, int exp);
    check(valid === 1'b1, req, "valid", int'(valid), 1);
    check(int'(offset) == exp, req, "offset", int'(offset), exp);
    check(rangeErr === (exp >= REGS), req, "rangeErr", int'(rangeErr), int'(exp >= REGS));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErrs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid === 1'b0, "R1", "valid in reset", int'(valid), 0);
    check(rangeErr === 1'b0, "R1", "rangeErr in reset", int'(rangeErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(valid === 1'b0, "R1", "valid after reset", int'(valid), 0);

    // R7: step while idle has no effect
    pulseStep();
    check(valid === 1'b0, "R7", "valid after idle step", int'(valid), 0);

    // table walk: R2 R3 R4 R5 R9
    for (int v = 0; v < 9; v++) begin
      loadCfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      check(valid === 1'b0, "R10", "valid after load", int'(valid), 0);
      pulseStart();
      checkOff("R6", VEC[v][4]);
      for (int n = 1; n < VEC[v][5]; n++) begin
        pulseStep();
        checkOff("R3", VEC[v][4] + modelIdx(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], n));
      end
    end

    // R2: hand-computed 4x1 sequence
    loadCfg(3, 0, 0, 0, 0);
    pulseStart();
    for (int n = 0; n < 16; n++) begin
      checkOff("R2", n % 4);
      pulseStep();
    end

    // R4: 2x3 wraps at 6 and repeats
    loadCfg(1, 2, 0, 0, 5);
    pulseStart();
    for (int n = 0; n < 13; n++) begin
      checkOff("R4", 5 + n % 6);
      pulseStep();
    end

    // R5: two unit axes collapse to linear order
    for (int p = 0; p < 8; p++) begin
      loadCfg(0, 0, 4, p, 2);
      pulseStart();
      for (int n = 0; n < 12; n++) begin
        checkOff("R5", 2 + n % 5);
        pulseStep();
      end
    end

    // R3: y fastest on 3x2x2, element 1 is one row away
    loadCfg(2, 1, 1, 2, 0);
    pulseStart();
    pulseStep();
    checkOff("R3", 3);

    // R7: hold without step
    repeat (4) @(negedge clk);
    checkOff("R7", 3);

    // R8: restart at zero
    pulseRestart(0);
    checkOff("R8", 0);

    // R10: load drops valid
    loadCfg(1, 1, 1, 0, 0);
    check(valid === 1'b0, "R10", "valid after load", int'(valid), 0);
    pulseStep();
    check(valid === 1'b0, "R7", "valid after step while idle", int'(valid), 0);

    // random shapes with restart: R8 R3
    for (int r = 0; r < 12; r++) begin
      int xd, yd, zd, pm, bs, k;
      xd = int'($urandom_range(0, 4));
      yd = int'($urandom_range(0, 4));
      zd = int'($urandom_range(0, 3));
      pm = int'($urandom_range(0, 7));
      bs = int'($urandom_range(0, 100));
      k  = int'($urandom_range(0, 40));
      loadCfg(xd, yd, zd, pm, bs);
      pulseStart();
      for (int n = 0; n < 20; n++) begin
        checkOff("R3", bs + modelIdx(xd, yd, zd, pm, n));
        pulseStep();
      end
      pulseRestart(k);
      if (k > 0) begin
        check(valid === 1'b0, "R8", "valid while seeking", int'(valid), 0);
        repeat (k - 1) @(negedge clk);
        check(valid === 1'b0, "R8", "valid before last seek", int'(valid), 0);
        @(negedge clk);
      end
      checkOff("R8", bs + modelIdx(xd, yd, zd, pm, k));
      for (int n = 1; n < 4; n++) begin
        pulseStep();
        checkOff("R8", bs + modelIdx(xd, yd, zd, pm, k + n));
      end
    end

    summary();
    $finish;
  end

endmodule